// File: doc/BRIEF.md
# Packed Trace History Buffer

This block records a running history of 6-bit trace codes. Whenever the capture enable is high, the code on the capture input is written into a circular store of 64 entries. A 6-bit write pointer then moves to the next slot. After 63 the pointer returns to 0, so the newest code always replaces the oldest one. The entries are laid end to end with no gaps, giving one 384-bit vector. A host sees that vector as twelve 32-bit words.

The host sends one command byte over a byte-wide valid/ready stream. The byte value is a fixed base plus a word index. After a fixed response delay, the block returns the selected word over a second byte-wide valid/ready stream, most significant byte first. The word is copied at the moment the command is accepted, so captures that arrive during readout cannot mix old and new data. The write pointer is always visible as a status output, so the host can tell the oldest entries in the unpacked history from the newest.

Top module: `trace_hist_buf`

## Requirements
- R1: After reset, `wr_ptr` is 0, `rsp_valid` is low and `cmd_ready` is high. The entry contents are undefined after reset.
- R2: On a clock edge with `cap_en` high, `cap_code` is stored in entry number `wr_ptr` and `wr_ptr` increases by one. With `cap_en` low, neither the pointer nor any entry changes.
- R3: The pointer wraps from 63 to 0. The capture at pointer 0 that follows overwrites the oldest entry.
- R4: Entry k occupies bits 6k+5..6k of a 384-bit packed vector. Word n is bits 32n+31..32n of that vector, so some entries are split across two words.
- R5: The command byte 0x50+n, for n from 0 to 11, returns word n as four bytes in this order: bits 31..24, 23..16, 15..8, 7..0.
- R6: The first byte becomes valid exactly `RESP_DELAY` clock edges after the edge that accepts the command. Each byte stays valid and unchanged until `rsp_ready` takes it.
- R7: `cmd_ready` is low from the edge that accepts a valid command until the edge that takes the fourth byte. It is high at all other times.
- R8: Any command byte outside 0x50..0x5B (including 0x5C..0x5F and bytes with a different upper nibble) is consumed without effect. No response follows, and `cmd_ready` stays high.
- R9: The returned word is the packed contents at the accepting edge. A capture in that same edge or during the delay or the transfer does not change the returned bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_en | input | 1 | Capture enable for the current trace code |
| cap_code | input | 6 | Trace code to record |
| wr_ptr | output | 6 | Entry that will be written next |
| cmd_valid | input | 1 | Command byte valid |
| cmd_byte | input | 8 | Command byte: base 0x50 plus word index |
| cmd_ready | output | 1 | Block can accept a command byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_byte | output | 8 | Response byte, most significant first |
| rsp_ready | input | 1 | Host takes the response byte |

## Verification
The history is filled past one full wrap with codes that change every cycle, with idle gaps where the enable is low. Reading back all twelve words then shows whether entries split across word boundaries are packed and ordered correctly and whether the wrap overwrites the right slot. Reads are run with the host always ready and with a stalling ready pattern, which separates delay and hold errors from byte-order errors. Out-of-range and foreign command bytes show that they are dropped. A read issued while captures continue on every cycle shows whether the word is copied at acceptance rather than tracked live.

// File: rtl/trace_hist_pkg.sv
package trace_hist_pkg;
  parameter int ENTRY_W  = 6;
  parameter int DEPTH    = 64;
  parameter int WORD_W   = 32;
  parameter int BYTE_W   = 8;
  parameter logic [7:0] CMD_BASE = 8'h50;

  localparam int PTR_W          = $clog2(DEPTH);
  localparam int TOTAL_BITS     = ENTRY_W * DEPTH;
  localparam int NUM_WORDS      = TOTAL_BITS / WORD_W;
  localparam int IDX_W          = $clog2(NUM_WORDS);
  localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
  localparam int BCNT_W         = $clog2(BYTES_PER_WORD);

  typedef enum logic [1:0] {RO_IDLE, RO_WAIT, RO_SEND} ro_state_e;

  // lowest bit of entry k inside the packed vector
  function automatic int entry_lsb(input int k);
    return k * ENTRY_W;
  endfunction

  // lowest bit of word n inside the packed vector
  function automatic int word_lsb(input int n);
    return n * WORD_W;
  endfunction

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic cmd_selects_word(input logic [7:0] b);
    return (b >= CMD_BASE) && (b < CMD_BASE + 8'(NUM_WORDS));
  endfunction

  // byte idx of a word, idx 0 being the most significant
  function automatic logic [BYTE_W-1:0] byte_of(input logic [WORD_W-1:0] w,
                                                input logic [BCNT_W-1:0] idx);
    logic [WORD_W-1:0] sh;
    sh = w >> (BYTE_W * (BYTES_PER_WORD - 1 - int'(idx)));
    return sh[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/trace_hist_store.sv
module trace_hist_store
  import trace_hist_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_en,
  input  logic [ENTRY_W-1:0]    cap_code,
  output logic [PTR_W-1:0]      wr_ptr,
  output logic [TOTAL_BITS-1:0] packed_bits
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (cap_en) ptr_q <= next_ptr(ptr_q);
  end

  assign wr_ptr = ptr_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    logic [ENTRY_W-1:0] ent_q;
    logic               hit;
    assign hit = cap_en && (ptr_q == PTR_W'(k));
    always_ff @(posedge clk) begin
      if (hit) ent_q <= cap_code;
    end
    assign packed_bits[entry_lsb(k) +: ENTRY_W] = ent_q;
  end
endmodule

// File: rtl/trace_hist_cmd_dec.sv
module trace_hist_cmd_dec
  import trace_hist_pkg::*;
(
  input  logic [7:0]       cmd_byte,
  output logic             is_read,
  output logic [IDX_W-1:0] word_idx
);
  logic [7:0] offset;

  assign offset   = cmd_byte - CMD_BASE;
  assign is_read  = cmd_selects_word(cmd_byte);
  assign word_idx = offset[IDX_W-1:0];
endmodule

// File: rtl/trace_hist_readout.sv
module trace_hist_readout
  import trace_hist_pkg::*;
#(
  parameter int RESP_DELAY = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TOTAL_BITS-1:0] packed_bits,
  input  logic                  cmd_valid,
  input  logic                  cmd_is_read,
  input  logic [IDX_W-1:0]      word_idx,
  output logic                  cmd_ready,
  output logic                  rsp_valid,
  output logic [BYTE_W-1:0]     rsp_byte,
  input  logic                  rsp_ready,
  output logic                  accept_evt,
  output logic [WORD_W-1:0]     snap_word
);
  localparam int CNT_W = (RESP_DELAY < 2) ? 1 : $clog2(RESP_DELAY + 1);
  localparam logic [BCNT_W-1:0] LAST_BYTE = BCNT_W'(BYTES_PER_WORD - 1);

  ro_state_e           state_q;
  logic [CNT_W-1:0]    dly_q;
  logic [BCNT_W-1:0]   bcnt_q;
  logic [WORD_W-1:0]   snap_q;
  logic [WORD_W-1:0]   word_arr [NUM_WORDS];
  logic [WORD_W-1:0]   sel_word;

  for (genvar n = 0; n < NUM_WORDS; n++) begin : g_word
    assign word_arr[n] = packed_bits[word_lsb(n) +: WORD_W];
  end

  always_comb begin
    sel_word = '0;
    for (int n = 0; n < NUM_WORDS; n++) begin
      if (word_idx == IDX_W'(n)) sel_word = word_arr[n];
    end
  end

  assign cmd_ready  = (state_q == RO_IDLE);
  assign accept_evt = cmd_valid && cmd_ready && cmd_is_read;
  assign rsp_valid  = (state_q == RO_SEND);
  assign rsp_byte   = byte_of(snap_q, bcnt_q);
  assign snap_word  = snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RO_IDLE;
      dly_q   <= '0;
      bcnt_q  <= '0;
      snap_q  <= '0;
    end else begin
      case (state_q)
        RO_IDLE: begin
          if (accept_evt) begin
            snap_q  <= sel_word;
            dly_q   <= CNT_W'(RESP_DELAY - 1);
            bcnt_q  <= '0;
            state_q <= RO_WAIT;
          end
        end
        RO_WAIT: begin
          if (dly_q == '0) state_q <= RO_SEND;
          else             dly_q   <= dly_q - CNT_W'(1);
        end
        RO_SEND: begin
          if (rsp_ready) begin
            if (bcnt_q == LAST_BYTE) state_q <= RO_IDLE;
            else                     bcnt_q  <= bcnt_q + BCNT_W'(1);
          end
        end
        default: state_q <= RO_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trace_hist_buf.sv
module trace_hist_buf
  import trace_hist_pkg::*;
#(
  parameter int RESP_DELAY = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_en,
  input  logic [ENTRY_W-1:0]    cap_code,
  output logic [PTR_W-1:0]      wr_ptr,
  input  logic                  cmd_valid,
  input  logic [7:0]            cmd_byte,
  output logic                  cmd_ready,
  output logic                  rsp_valid,
  output logic [BYTE_W-1:0]     rsp_byte,
  input  logic                  rsp_ready
);
  logic [TOTAL_BITS-1:0] packed_bits;
  logic                  cmd_is_read;
  logic [IDX_W-1:0]      word_idx;
  logic                  accept_evt;
  logic [WORD_W-1:0]     snap_word;

  trace_hist_store store_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (cap_en),
    .cap_code    (cap_code),
    .wr_ptr      (wr_ptr),
    .packed_bits (packed_bits)
  );

  trace_hist_cmd_dec dec_i (
    .cmd_byte (cmd_byte),
    .is_read  (cmd_is_read),
    .word_idx (word_idx)
  );

  trace_hist_readout #(.RESP_DELAY(RESP_DELAY)) ro_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .packed_bits (packed_bits),
    .cmd_valid   (cmd_valid),
    .cmd_is_read (cmd_is_read),
    .word_idx    (word_idx),
    .cmd_ready   (cmd_ready),
    .rsp_valid   (rsp_valid),
    .rsp_byte    (rsp_byte),
    .rsp_ready   (rsp_ready),
    .accept_evt  (accept_evt),
    .snap_word   (snap_word)
  );
endmodule

// File: rtl/trace_hist_buf_chk.sv
module trace_hist_buf_chk
  import trace_hist_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cap_en,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_is_read,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BYTE_W-1:0] rsp_byte,
  input logic              accept_evt,
  input logic [WORD_W-1:0] snap_word
);
  // R2 R3
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> wr_ptr == PTR_W'($past(wr_ptr) + PTR_W'(1)));

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(wr_ptr));

  // R6
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

  // R6
  no_early_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (!rsp_valid && !cmd_ready));

  // R7
  busy_while_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  // R8
  bad_cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_is_read) |=> (cmd_ready && !rsp_valid));

  // R9
  snap_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && cap_en) |=> $stable(snap_word));
endmodule

bind trace_hist_buf trace_hist_buf_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cap_en      (cap_en),
  .wr_ptr      (wr_ptr),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_is_read (cmd_is_read),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_byte    (rsp_byte),
  .accept_evt  (accept_evt),
  .snap_word   (snap_word)
);

// File: tb/trace_hist_buf_tb.sv
module trace_hist_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 3;
  localparam int WDOG_LIMIT = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_en = 1'b0;
  logic [5:0] cap_code = '0;
  logic [5:0] wr_ptr;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       cmd_ready;
  logic       rsp_valid;
  logic [7:0] rsp_byte;
  logic       rsp_ready = 1'b1;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string byte_tag = "R4/R5";

  // reference model state
  int  m_mem [64];
  int  m_wp = 0;
  bit  m_busy = 1'b0;
  int  m_wait = 0;
  int  m_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_hist_buf #(.RESP_DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_code(cap_code),
    .wr_ptr(wr_ptr), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .rsp_ready(rsp_ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // bit g of the history: entry g/6, bit g%6
  function automatic int model_word(input int n);
    int w = 0;
    for (int b = 0; b < 32; b++) begin
      int g = 32 * n + b;
      if ((m_mem[g / 6] >> (g % 6)) & 1) w = w | (1 << b);
    end
    return w;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_wp = 0; m_busy = 1'b0; m_wait = 0; m_q.delete();
    end else begin
      bit acc;
      acc = cmd_valid && !m_busy;
      if (m_busy && m_wait == 0) begin
        if (rsp_ready) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_busy = 1'b0;
        end
      end else if (m_busy) begin
        m_wait--;
      end
      if (acc && cmd_byte >= 8'h50 && cmd_byte <= 8'h5B) begin
        int w;
        w = model_word(int'(cmd_byte) - 'h50);
        for (int i = 3; i >= 0; i--) m_q.push_back((w >> (8 * i)) & 'hFF);
        m_wait = DLY;
        m_busy = 1'b1;
      end
      if (cap_en) begin
        m_mem[m_wp] = int'(cap_code);
        m_wp = (m_wp + 1) % 64;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      bit ev;
      ev = m_busy && m_wait == 0;
      check(int'(wr_ptr) == m_wp, "R2 wr_ptr", int'(wr_ptr), m_wp);
      check(cmd_ready == !m_busy, "R7 cmd_ready", int'(cmd_ready), int'(!m_busy));
      check(rsp_valid == ev, "R6 rsp_valid", int'(rsp_valid), int'(ev));
      if (ev && rsp_valid)
        check(int'(rsp_byte) == m_q[0], byte_tag, int'(rsp_byte), m_q[0]);
    end
  end

  always @(posedge clk) begin
    if (cycles > WDOG_LIMIT && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WDOG_LIMIT);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic read_word(input int n, input bit stall);
    int gap = 0;
    int taken = 0;
    int k = 0;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = 8'(8'h50 + n);
    @(negedge clk);
    gap++;
    cmd_valid = 1'b0;
    while (!rsp_valid) begin
      @(negedge clk);
      gap++;
    end
    // R6: first byte visible DLY edges after the accepting edge
    check(gap == DLY + 1, "R6 delay", gap, DLY + 1);
    while (taken < 4) begin
      rsp_ready = stall ? k[0] : 1'b1;
      k++;
      if (rsp_valid && rsp_ready) taken++;
      @(negedge clk);
    end
    rsp_ready = 1'b1;
  endtask

  task automatic bad_cmd(input logic [7:0] b);
    int seen = 0;
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < DLY + 4; i++) begin
      if (rsp_valid || !cmd_ready) seen++;
      @(negedge clk);
    end
    // R8
    check(seen == 0, "R8 ignored command", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(wr_ptr == 6'd0, "R1 wr_ptr", int'(wr_ptr), 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    check(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk_on = 1'b1;

    // fill past one wrap, with idle gaps (R2, R3)
    for (int i = 0; i < 80; i++) begin
      cap_en   = (i % 7) != 3;
      cap_code = 6'((i * 37 + 11) & 63);
      @(negedge clk);
    end
    cap_en = 1'b0;
    @(negedge clk);
    // 80 cycles, 11 of them idle: 69 captures, wraps to 5
    check(wr_ptr == 6'd5, "R3 wrap", int'(wr_ptr), 5);

    for (int n = 0; n < 12; n++) read_word(n, 1'b0);
    read_word(1, 1'b1);
    read_word(11, 1'b1);

    bad_cmd(8'h5C);
    bad_cmd(8'h5F);
    bad_cmd(8'h31);
    bad_cmd(8'h4B);

    // R9: captures on every cycle during readout
    byte_tag = "R9 snapshot";
    fork
      read_word(0, 1'b1);
      begin
        for (int i = 0; i < 20; i++) begin
          cap_en   = 1'b1;
          cap_code = 6'((i * 5 + 3) & 63);
          @(negedge clk);
        end
        cap_en = 1'b0;
      end
    join
    byte_tag = "R4/R5";
    read_word(0, 1'b0);
    read_word(6, 1'b0);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule